// File: doc/BRIEF.md
# Compressed-Instruction Output Realigner

This block sits between a fetch path that delivers aligned 32-bit beats and a core that consumes one instruction at a time. It splits each beat into half-words and decides from the low two bits of each half-word whether it starts a 16-bit compressed instruction or a 32-bit uncompressed one. It then presents exactly one instruction per handshake together with its byte address.

An uncompressed instruction that starts in the upper half of a beat straddles two beats. The upper half-word of the first beat is kept in a one-entry skid register until the next beat arrives. A compressed instruction left in the skid register is issued without waiting for a new beat. A branch redirects the block to an even target address, flushes any pending output and discards the skid contents. Bus errors from the beats are attributed to the instructions built from them. A second flag marks the case where only the second half of a straddling instruction came from a faulty beat.

Top module: `instr_realign`

## Requirements
- R1: A half-word whose bits [1:0] are 2'b11 starts a 32-bit instruction; any other value is a 16-bit instruction, presented on out_data[15:0] with out_data[31:16] zero.
- R2: Beats are consumed in order starting at the word holding the branch target (target with bits [1:0] cleared). Successive issued addresses advance by 2 after a 16-bit and by 4 after a 32-bit instruction, and each instruction's data is the memory content at its address.
- R3: A 32-bit instruction at an address with bit 1 set is issued as {lower half of the next beat, upper half of the previous beat}.
- R4: The skid register is valid only while the next instruction address has bit 1 set.
- R5: A branch drops out_valid and the skid contents at the next clock edge. The stream then restarts at the target; a target with bit 1 set starts in the upper half of its first beat.
- R6: Once out_valid is high it falls only after a cycle with out_ready or branch high.
- R7: While out_valid is held without out_ready or branch, out_addr, out_err and out_err_hi stay stable. out_data[15:0] stays stable when out_err is clear, and out_data[31:16] stays stable for a 32-bit instruction.
- R8: out_err is set when any beat that supplied part of the instruction arrived with beat_err set.
- R9: out_err_hi is set only with out_err on a 32-bit instruction, exactly when the beat holding its first half was clean and the beat holding its second half was faulty.
- R10: During reset out_valid and beat_ready are low. After reset the first instruction is issued from RESET_ADDR.
- R11: beat_ready is low while an instruction is held without out_ready, and while a 16-bit instruction already in the skid register is being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| branch | input | 1 | Redirect to branch_tgt this cycle |
| branch_tgt | input | ADDR_W | Even branch target address |
| beat_valid | input | 1 | A fetched beat is present |
| beat_ready | output | 1 | The block takes the beat at this edge |
| beat_data | input | 32 | Fetched aligned word |
| beat_err | input | 1 | The beat carries a bus error |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | The core takes the instruction |
| out_data | output | 32 | Instruction bits |
| out_addr | output | ADDR_W | Instruction byte address |
| out_err | output | 1 | The instruction touched a faulty beat |
| out_err_hi | output | 1 | Only the second half came from a faulty beat |

## Verification
A wrong alignment state shows up as a wrong out_addr or as out_data built from the wrong half-words. This happens on the very next instruction issued after the fault, because the address step and the half-word chosen both depend on that state. A lost or stale skid register shows up in the same handshake as a straddling instruction with a wrong upper or lower half. It can also show as an error flag taken from the wrong beat. A handshake fault shows within one cycle: out_valid falls without a take, the held fields change, or beat_ready is high while the output is stalled.

// File: rtl/realign_pkg.sv
package realign_pkg;

  localparam int HALF_W = 16;
  localparam int BEAT_W = 2 * HALF_W;

  // Alignment position: {next address bit 1, skid register valid}
  typedef enum logic [1:0] {
    POS_EVEN      = 2'b00,
    POS_BAD       = 2'b01,
    POS_ODD_EMPTY = 2'b10,
    POS_ODD_HELD  = 2'b11
  } pos_e;

  function automatic logic is_wide(input logic [HALF_W-1:0] h);
    return h[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/realign_seq.sv
module realign_seq
  import realign_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic [ADDR_W-1:0] branch_tgt,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic              beat_err,
  input  logic              take,
  output logic              beat_ready,
  output logic              emit,
  output logic [BEAT_W-1:0] emit_data,
  output logic [ADDR_W-1:0] emit_addr,
  output logic              emit_err,
  output logic              emit_err_hi,
  output logic              skid_valid,
  output logic              pc_odd
);

  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;
  logic              skid_v_q;
  logic [HALF_W-1:0] skid_d_q;
  logic              skid_e_q;

  logic [HALF_W-1:0] lo_h, hi_h;
  pos_e              pos;
  logic              need_beat, emit_c, err_c, err_hi_c;
  logic              sk_load, sk_clear, fire;
  logic [BEAT_W-1:0] data_c;
  logic [2:0]        step_c;

  assign lo_h = beat_data[HALF_W-1:0];
  assign hi_h = beat_data[BEAT_W-1:HALF_W];
  assign pos  = pos_e'({pc_q[1], skid_v_q});

  always_comb begin
    need_beat = 1'b0;
    emit_c    = 1'b0;
    data_c    = '0;
    err_c     = 1'b0;
    err_hi_c  = 1'b0;
    step_c    = 3'd0;
    sk_load   = 1'b0;
    sk_clear  = 1'b0;
    unique case (pos)
      POS_EVEN: begin
        need_beat = 1'b1;
        emit_c    = 1'b1;
        err_c     = beat_err;
        if (is_wide(lo_h)) begin
          data_c   = beat_data;
          step_c   = 3'd4;
          sk_clear = 1'b1;
        end else begin
          data_c  = {{HALF_W{1'b0}}, lo_h};
          step_c  = 3'd2;
          sk_load = 1'b1;
        end
      end
      POS_ODD_EMPTY: begin
        need_beat = 1'b1;
        if (is_wide(hi_h)) begin
          sk_load = 1'b1;
        end else begin
          emit_c   = 1'b1;
          data_c   = {{HALF_W{1'b0}}, hi_h};
          err_c    = beat_err;
          step_c   = 3'd2;
          sk_clear = 1'b1;
        end
      end
      POS_ODD_HELD: begin
        emit_c = 1'b1;
        if (is_wide(skid_d_q)) begin
          need_beat = 1'b1;
          data_c    = {lo_h, skid_d_q};
          err_c     = skid_e_q | beat_err;
          err_hi_c  = ~skid_e_q & beat_err;
          step_c    = 3'd4;
          sk_load   = 1'b1;
        end else begin
          data_c   = {{HALF_W{1'b0}}, skid_d_q};
          err_c    = skid_e_q;
          step_c   = 3'd2;
          sk_clear = 1'b1;
        end
      end
      default: begin
        sk_clear = 1'b1;
      end
    endcase
  end

  assign fire       = ~rst & ~branch & take & (~need_beat | beat_valid);
  assign beat_ready = ~rst & ~branch & take & need_beat;
  assign emit       = fire & emit_c;

  assign emit_data   = data_c;
  assign emit_addr   = pc_q;
  assign emit_err    = err_c;
  assign emit_err_hi = err_hi_c;
  assign skid_valid  = skid_v_q;
  assign pc_odd      = pc_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_ADDR & EVEN_MASK;
      skid_v_q <= 1'b0;
      skid_d_q <= '0;
      skid_e_q <= 1'b0;
    end else if (branch) begin
      pc_q     <= branch_tgt & EVEN_MASK;
      skid_v_q <= 1'b0;
    end else if (fire) begin
      pc_q <= pc_q + ADDR_W'(step_c);
      if (sk_load) begin
        skid_v_q <= 1'b1;
        skid_d_q <= hi_h;
        skid_e_q <= beat_err;
      end else if (sk_clear) begin
        skid_v_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/realign_outreg.sv
module realign_outreg
  import realign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic              out_ready,
  input  logic              emit,
  input  logic [BEAT_W-1:0] emit_data,
  input  logic [ADDR_W-1:0] emit_addr,
  input  logic              emit_err,
  input  logic              emit_err_hi,
  output logic              take,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err,
  output logic              out_err_hi
);

  logic              valid_q;
  logic [BEAT_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q, err_hi_q;

  assign take = ~valid_q | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      data_q   <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      err_hi_q <= 1'b0;
    end else if (branch) begin
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= emit;
      if (emit) begin
        data_q   <= emit_data;
        addr_q   <= emit_addr;
        err_q    <= emit_err;
        err_hi_q <= emit_err_hi;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_data   = data_q;
  assign out_addr   = addr_q;
  assign out_err    = err_q;
  assign out_err_hi = err_hi_q;

endmodule

// File: rtl/instr_realign.sv
module instr_realign
  import realign_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic [ADDR_W-1:0] branch_tgt,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [31:0]       beat_data,
  input  logic              beat_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err,
  output logic              out_err_hi
);

  logic              take, emit, emit_err, emit_err_hi;
  logic [BEAT_W-1:0] emit_data;
  logic [ADDR_W-1:0] emit_addr;
  logic              skid_valid, pc_odd;

  realign_seq #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .branch      (branch),
    .branch_tgt  (branch_tgt),
    .beat_valid  (beat_valid),
    .beat_data   (beat_data),
    .beat_err    (beat_err),
    .take        (take),
    .beat_ready  (beat_ready),
    .emit        (emit),
    .emit_data   (emit_data),
    .emit_addr   (emit_addr),
    .emit_err    (emit_err),
    .emit_err_hi (emit_err_hi),
    .skid_valid  (skid_valid),
    .pc_odd      (pc_odd)
  );

  realign_outreg #(
    .ADDR_W (ADDR_W)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .branch      (branch),
    .out_ready   (out_ready),
    .emit        (emit),
    .emit_data   (emit_data),
    .emit_addr   (emit_addr),
    .emit_err    (emit_err),
    .emit_err_hi (emit_err_hi),
    .take        (take),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_addr    (out_addr),
    .out_err     (out_err),
    .out_err_hi  (out_err_hi)
  );

endmodule

// File: rtl/realign_chk.sv
module realign_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              branch,
  input logic              beat_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_err,
  input logic              out_err_hi,
  input logic              skid_valid,
  input logic              pc_odd
);

  // R1
  p_narrow_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[1:0] != 2'b11) |-> out_data[31:16] == 16'h0);

  // R4
  p_skid_odd_r4: assert property (@(posedge clk) disable iff (rst)
    skid_valid |-> pc_odd);

  // R5
  p_branch_flush_r5: assert property (@(posedge clk) disable iff (rst)
    branch |=> (!out_valid && !skid_valid));

  // R6
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready || branch));

  // R7
  p_held_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !branch) |=>
      (out_valid && $stable(out_addr) && $stable(out_err) && $stable(out_err_hi)));

  p_lo_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !branch && !out_err) |=> $stable(out_data[15:0]));

  p_hi_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !branch && out_data[1:0] == 2'b11) |=>
      $stable(out_data[31:16]));

  // R9
  p_err_hi_wide_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err_hi) |-> (out_err && out_data[1:0] == 2'b11));

  // R10
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R11
  p_no_beat_stalled_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !beat_ready);

endmodule

bind instr_realign realign_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .branch     (branch),
  .beat_ready (beat_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_addr   (out_addr),
  .out_err    (out_err),
  .out_err_hi (out_err_hi),
  .skid_valid (skid_valid),
  .pc_odd     (pc_odd)
);

// File: tb/instr_realign_tb.sv
`timescale 1ns/1ps
module instr_realign_tb;

  typedef struct packed {
    logic [31:0] tgt;
    logic [7:0]  n;
    logic [1:0]  rmode;
    logic [1:0]  bmode;
    logic [31:0] errw;
  } vec_t;

  localparam logic [31:0] NOERR = 32'hFFFF_FFFC;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0100, 8'd20, 2'd0, 2'd0, NOERR},
    '{32'h0000_0202, 8'd20, 2'd0, 2'd0, NOERR},
    '{32'h0000_0300, 8'd16, 2'd1, 2'd1, NOERR},
    '{32'h0000_0406, 8'd16, 2'd2, 2'd2, NOERR},
    '{32'h0000_0500, 8'd10, 2'd0, 2'd0, 32'h0000_0508},
    '{32'h0000_0602, 8'd12, 2'd1, 2'd0, 32'h0000_0608},
    '{32'h0000_0700, 8'd12, 2'd0, 2'd1, 32'h0000_0704},
    '{32'h0000_080A, 8'd12, 2'd2, 2'd0, 32'h0000_0810}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branch = 1'b0;
  logic [31:0] branch_tgt = '0;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic [31:0] beat_data = '0;
  logic        beat_err = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [31:0] out_addr;
  logic        out_err;
  logic        out_err_hi;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  instr_realign #(.ADDR_W(32), .RESET_ADDR(32'h0)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .branch     (branch),
    .branch_tgt (branch_tgt),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_data  (beat_data),
    .beat_err   (beat_err),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_addr   (out_addr),
    .out_err    (out_err),
    .out_err_hi (out_err_hi)
  );

  function automatic logic [15:0] mem_h(input logic [31:0] a);
    logic [31:0] x;
    logic [15:0] h;
    x = a * 32'h9E37_79B1;
    h = x[31:16];
    if (((a >> 1) % 3) == 0) h[1:0] = 2'b11;
    else if (h[1:0] == 2'b11) h[1:0] = 2'b10;
    return h;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] w);
    return {mem_h(w + 32'd2), mem_h(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_stream(input logic [31:0] tgt, input int n, input int rm,
                            input int bm, input logic [31:0] errw, input bit do_br);
    logic [31:0] fptr, ea, ed, sv_addr, sv_data;
    logic [15:0] h0;
    logic        wide, e0, e1, sv_err, sv_hi, held, first;
    int          k, guard;
    if (do_br) begin
      @(negedge clk);
      branch     = 1'b1;
      branch_tgt = tgt;
      beat_valid = 1'b0;
      out_ready  = 1'b0;
    end
    fptr = tgt & ~32'd3;
    ea = tgt; k = 0; guard = 0; held = 1'b0; first = 1'b1;
    sv_addr = '0; sv_data = '0; sv_err = 1'b0; sv_hi = 1'b0;
    while (k < n && guard < 3000) begin
      @(negedge clk);
      branch = 1'b0;
      cyc++;
      out_ready  = (rm == 0) ? 1'b1 : (rm == 1) ? ((cyc % 2) == 0) : ((cyc % 3) == 0);
      beat_valid = (bm == 0) ? 1'b1 : (bm == 1) ? ((cyc % 4) != 1) : ((cyc % 2) == 0);
      beat_data  = word_at(fptr);
      beat_err   = (fptr == errw);
      #1;
      if (first && do_br)
        chk(out_valid == 1'b0, "R5 valid dropped after branch", 64'(out_valid), 64'd0);
      first = 1'b0;
      if (held) begin
        chk(out_valid == 1'b1, "R6 valid held until taken", 64'(out_valid), 64'd1);
        chk({out_addr, out_err, out_err_hi} == {sv_addr, sv_err, sv_hi},
            "R7 held addr/err stable", {30'd0, out_addr, out_err, out_err_hi},
            {30'd0, sv_addr, sv_err, sv_hi});
        chk(out_data == sv_data, "R7 held data stable", 64'(out_data), 64'(sv_data));
      end
      if (out_valid && !out_ready)
        chk(beat_ready == 1'b0, "R11 no beat while stalled", 64'(beat_ready), 64'd0);
      if (beat_valid && beat_ready) fptr = fptr + 32'd4;
      if (out_valid && out_ready) begin
        h0   = mem_h(ea);
        wide = (h0[1:0] == 2'b11);
        ed   = wide ? {mem_h(ea + 32'd2), h0} : {16'h0, h0};
        e0   = ((ea & ~32'd3) == errw);
        e1   = (((ea + 32'd2) & ~32'd3) == errw);
        chk(out_addr == ea, "R2 address sequence", 64'(out_addr), 64'(ea));
        if (wide && ea[1])
          chk(out_data == ed, "R3 R4 straddled data", 64'(out_data), 64'(ed));
        else
          chk(out_data == ed, "R1 instruction data", 64'(out_data), 64'(ed));
        chk(out_err == (e0 | (wide & e1)), "R8 error flag", 64'(out_err),
            64'(e0 | (wide & e1)));
        chk(out_err_hi == (wide & ~e0 & e1), "R9 second-half error", 64'(out_err_hi),
            64'(wide & ~e0 & e1));
        ea = ea + (wide ? 32'd4 : 32'd2);
        k++;
      end
      held    = out_valid && !out_ready;
      sv_addr = out_addr; sv_data = out_data; sv_err = out_err; sv_hi = out_err_hi;
      guard++;
    end
    if (k < n) chk(1'b0, "R2 stream stalled", 64'(k), 64'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 valid low in reset", 64'(out_valid), 64'd0);
    chk(beat_ready == 1'b0, "R10 beat_ready low in reset", 64'(beat_ready), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(beat_ready == 1'b1, "R10 ready for first beat", 64'(beat_ready), 64'd1);
    // R10: stream from reset address without a branch
    run_stream(32'h0, 8, 0, 0, NOERR, 1'b0);

    // table of vectors
    for (int i = 0; i < NVEC; i++)
      run_stream(VECS[i].tgt, int'(VECS[i].n), int'(VECS[i].rmode), int'(VECS[i].bmode),
                 VECS[i].errw, 1'b1);

    // R6 R5: hold an instruction, then cancel it with a branch to an odd half-word
    @(negedge clk);
    out_ready = 1'b0;
    beat_valid = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R6 valid stays without ready", 64'(out_valid), 64'd1);
    run_stream(32'h0000_0902, 10, 0, 0, NOERR, 1'b1);

    // R5: back-to-back branches, second one wins
    @(negedge clk);
    branch = 1'b1; branch_tgt = 32'h0000_0A00; beat_valid = 1'b1; out_ready = 1'b1;
    run_stream(32'h0000_0B06, 10, 1, 2, 32'h0000_0B08, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule